// File: doc/BRIEF.md
# Packet Buffer Frame Formatter

This block moves packets between byte streams and a 16-bit word buffer, using a fixed layout for every stored packet. A write job takes a base word address, a payload length in bytes and a status value. It then accepts the payload on a valid/ready byte stream. It stores one status word and one byte-count word, then the payload in byte pairs, and closes the packet with one control word. When the length is odd, that control word carries the last payload byte together with a flag bit.

A read job takes a base word address. It fetches the two header words and rejects the packet if any error status bit is set or if the length comes out negative. Otherwise it works out the real payload length and sends the payload on a valid/ready byte stream. Each job walks the buffer with its own word pointer. The pointer steps by one after every word access and wraps at the end of the buffer. The write side and the read side have separate buffer ports, so one packet can be stored while another is read.

On both streams a byte moves only in a cycle where valid and ready are both high. The write side raises `tx_in_ready` only while it waits for a payload byte. The read side keeps `rx_out_valid`, `rx_out_data` and `rx_out_last` unchanged for as long as `rx_out_ready` stays low.

Top module: `pkt_frame_fmt`

## Requirements
- R1: After a write job of length L with status S at base B, the word at B holds S and the word at B+1 holds L+6, zero-extended to 16 bits.
- R2: Payload bytes 2k and 2k+1 are stored at word B+2+k, with byte 2k in bits 7:0 and byte 2k+1 in bits 15:8.
- R3: The control word sits at B+2+floor(L/2). For odd L it is 0x2000 ORed with the last payload byte in bits 7:0, so the flag is bit 13. For even L it is 0x0000.
- R4: `tx_in_ready` is high only while a payload byte is awaited. Exactly L bytes are taken, and after the control word is written `tx_done` pulses high for one cycle and the block goes idle.
- R5: A read job reports the length as count[10:0] + status[12] - 6, where count is the word at B+1 and status is the word at B.
- R6: If the status word has any bit set under mask 0xAC00, the read ends with `rx_err`=1 and `rx_len`=0, and no byte is sent.
- R7: If count[10:0] + status[12] is below 6, the read ends with `rx_err`=1 and `rx_len`=0, and no byte is sent.
- R8: Payload bytes come out in order, starting at word B+2 with the low byte first. `rx_out_last` marks the final byte. Valid, data and last stay unchanged while ready is low.
- R9: `rx_done` pulses for one cycle after the last byte is accepted, or right after the header when no byte is due. `rx_err` and `rx_len` are valid in that cycle and hold until the next job ends.
- R10: Buffer addresses wrap modulo the buffer depth (1024 words by default), so a packet may start near the top and continue from word 0.
- R11: A start request on either side is ignored while that side is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_start | input | 1 | Start a write job (taken only when idle) |
| tx_base | input | 10 | Base word address of the packet to write |
| tx_len | input | 11 | Payload length in bytes |
| tx_status | input | 16 | Value stored in the status word |
| tx_busy | output | 1 | Write job in progress |
| tx_done | output | 1 | One-cycle pulse when the write job ends |
| tx_in_valid | input | 1 | Payload byte valid |
| tx_in_data | input | 8 | Payload byte |
| tx_in_ready | output | 1 | Block accepts a payload byte |
| rx_start | input | 1 | Start a read job (taken only when idle) |
| rx_base | input | 10 | Base word address of the packet to read |
| rx_busy | output | 1 | Read job in progress |
| rx_out_valid | output | 1 | Output byte valid |
| rx_out_ready | input | 1 | Consumer accepts the output byte |
| rx_out_data | output | 8 | Output payload byte |
| rx_out_last | output | 1 | Output byte is the final payload byte |
| rx_done | output | 1 | One-cycle pulse when the read job ends |
| rx_err | output | 1 | Error result of the last read job |
| rx_len | output | 11 | Payload length of the last read job (0 on error) |

## Verification
The bench stores packets and reads each one back through the output stream. This shows the control word directly in three cases. An odd payload read with the odd-frame status bit set must end in 0x20. An even payload with that bit set must end in 0x00. Plain odd payloads must end with their own last byte; a design that padded the wrong half or misplaced the flag would emit a wrong final byte. Two error status bits are tried, and a maximum-length packet pushes the masked count to zero; a design that skipped either check would stream garbage or report a wrapped length. A packet placed across the top of the buffer catches pointers that fail to wrap. Random stalls on the output stream catch bytes that are dropped or that change under back-pressure. Extra start pulses during busy jobs catch a restart that would corrupt the stored or streamed packet.

// File: rtl/pfmt_pkg.sv
package pfmt_pkg;
  localparam int WORD_W       = 16;
  localparam int LEN_W        = 11;
  localparam int HDR_BYTES    = 6;
  localparam int CTRL_ODD_BIT = 13;
  localparam int RX_ODD_BIT   = 12;
  localparam logic [WORD_W-1:0] RX_ERR_MASK = 16'hAC00;

  typedef enum logic [2:0] {
    TX_IDLE, TX_STAT, TX_CNT, TX_DATA, TX_CTRL
  } tx_state_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_HDR0, RX_HDR1, RX_EVAL, RX_FETCH, RX_LOAD, RX_SEND
  } rx_state_e;
endpackage

// File: rtl/pfmt_word_ram.sv
module pfmt_word_ram #(
  parameter int DEPTH = 1024,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pfmt_tx_packer.sv
module pfmt_tx_packer
  import pfmt_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     base,
  input  logic [LEN_W-1:0]  len,
  input  logic [WORD_W-1:0] status,
  output logic              busy,
  output logic              done,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              we,
  output logic [AW-1:0]     waddr,
  output logic [WORD_W-1:0] wdata
);
  tx_state_e         st;
  logic [AW-1:0]     ptr;
  logic [LEN_W-1:0]  len_q;
  logic [WORD_W-1:0] stat_q;
  logic [LEN_W-1:0]  byte_cnt;
  logic [7:0]        lo_q;
  logic              acc;
  logic [LEN_W-1:0]  even_len;

  assign even_len = {len_q[LEN_W-1:1], 1'b0};
  assign busy     = (st != TX_IDLE);
  assign in_ready = (st == TX_DATA) || (st == TX_CTRL && len_q[0]);
  assign acc      = in_valid && in_ready;
  assign waddr    = ptr;

  always_comb begin
    we    = 1'b0;
    wdata = '0;
    unique case (st)
      TX_STAT: begin we = 1'b1; wdata = stat_q; end
      TX_CNT:  begin we = 1'b1; wdata = WORD_W'(len_q) + WORD_W'(HDR_BYTES); end
      TX_DATA: begin we = acc && byte_cnt[0]; wdata = {in_data, lo_q}; end
      TX_CTRL: begin
        we    = !len_q[0] || acc;
        wdata = len_q[0] ? ((WORD_W'(1) << CTRL_ODD_BIT) | {8'h00, in_data}) : '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= TX_IDLE;
      ptr      <= '0;
      len_q    <= '0;
      stat_q   <= '0;
      byte_cnt <= '0;
      lo_q     <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        TX_IDLE: if (start) begin
          ptr      <= base;
          len_q    <= len;
          stat_q   <= status;
          byte_cnt <= '0;
          st       <= TX_STAT;
        end
        TX_STAT: begin ptr <= ptr + 1'b1; st <= TX_CNT; end
        TX_CNT: begin
          ptr <= ptr + 1'b1;
          st  <= (even_len == '0) ? TX_CTRL : TX_DATA;
        end
        TX_DATA: if (acc) begin
          byte_cnt <= byte_cnt + 1'b1;
          if (!byte_cnt[0]) lo_q <= in_data;
          else begin
            ptr <= ptr + 1'b1;
            if (byte_cnt + 1'b1 == even_len) st <= TX_CTRL;
          end
        end
        TX_CTRL: if (we) begin
          ptr  <= ptr + 1'b1;
          done <= 1'b1;
          st   <= TX_IDLE;
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  // R10: every buffer write advances the pointer by one, modulo the depth
  p_ptr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ptr == $past(ptr) + 1'b1);
  // R11: job fields stay fixed while a job runs
  p_job_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st != TX_IDLE) |=> $stable(len_q) && $stable(stat_q));
  // R4: done is a single-cycle pulse
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/pfmt_rx_unpacker.sv
module pfmt_rx_unpacker
  import pfmt_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     base,
  output logic              busy,
  output logic [AW-1:0]     raddr,
  input  logic [WORD_W-1:0] rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic              done,
  output logic              err,
  output logic [LEN_W-1:0]  len
);
  rx_state_e         st;
  logic [AW-1:0]     ptr;
  logic [WORD_W-1:0] stat_q;
  logic [WORD_W-1:0] word_q;
  logic [LEN_W-1:0]  remain;
  logic              half;
  logic [LEN_W:0]    sum;
  logic              bad;
  logic [LEN_W-1:0]  plen;

  assign raddr     = ptr;
  assign busy      = (st != RX_IDLE);
  assign out_valid = (st == RX_SEND);
  assign out_data  = half ? word_q[15:8] : word_q[7:0];
  assign out_last  = out_valid && (remain == LEN_W'(1));

  // length arithmetic on the count word (read data during RX_EVAL)
  always_comb begin
    sum  = {1'b0, rdata[LEN_W-1:0]} + {{LEN_W{1'b0}}, stat_q[RX_ODD_BIT]};
    bad  = (|(stat_q & RX_ERR_MASK)) || (sum < (LEN_W+1)'(HDR_BYTES));
    plen = LEN_W'(sum - (LEN_W+1)'(HDR_BYTES));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= RX_IDLE;
      ptr    <= '0;
      stat_q <= '0;
      word_q <= '0;
      remain <= '0;
      half   <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
      len    <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        RX_IDLE: if (start) begin ptr <= base; st <= RX_HDR0; end
        RX_HDR0: begin ptr <= ptr + 1'b1; st <= RX_HDR1; end
        RX_HDR1: begin stat_q <= rdata; ptr <= ptr + 1'b1; st <= RX_EVAL; end
        RX_EVAL: begin
          if (bad || plen == '0) begin
            done <= 1'b1;
            err  <= bad;
            len  <= '0;
            st   <= RX_IDLE;
          end else begin
            len    <= plen;
            remain <= plen;
            half   <= 1'b0;
            st     <= RX_FETCH;
          end
        end
        RX_FETCH: begin ptr <= ptr + 1'b1; half <= 1'b0; st <= RX_LOAD; end
        RX_LOAD:  begin word_q <= rdata; st <= RX_SEND; end
        RX_SEND: if (out_ready) begin
          remain <= remain - 1'b1;
          if (remain == LEN_W'(1)) begin
            done <= 1'b1;
            err  <= 1'b0;
            st   <= RX_IDLE;
          end else if (half) st <= RX_FETCH;
          else half <= 1'b1;
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  // R8: a stalled byte is held unchanged
  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
  // R6: an error ending never coincides with an offered byte
  p_err_no_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && err |-> !out_valid);
  // R9: done is a single-cycle pulse and results hold afterwards
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && $stable(err) && $stable(len));
endmodule

// File: rtl/pkt_frame_fmt.sv
module pkt_frame_fmt
  import pfmt_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_start,
  input  logic [AW-1:0]     tx_base,
  input  logic [LEN_W-1:0]  tx_len,
  input  logic [WORD_W-1:0] tx_status,
  output logic              tx_busy,
  output logic              tx_done,
  input  logic              tx_in_valid,
  input  logic [7:0]        tx_in_data,
  output logic              tx_in_ready,
  input  logic              rx_start,
  input  logic [AW-1:0]     rx_base,
  output logic              rx_busy,
  output logic              rx_out_valid,
  input  logic              rx_out_ready,
  output logic [7:0]        rx_out_data,
  output logic              rx_out_last,
  output logic              rx_done,
  output logic              rx_err,
  output logic [LEN_W-1:0]  rx_len
);
  logic              we;
  logic [AW-1:0]     waddr;
  logic [WORD_W-1:0] wdata;
  logic [AW-1:0]     raddr;
  logic [WORD_W-1:0] rdata;

  pfmt_tx_packer #(.AW(AW)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .base(tx_base), .len(tx_len),
    .status(tx_status), .busy(tx_busy), .done(tx_done), .in_valid(tx_in_valid),
    .in_data(tx_in_data), .in_ready(tx_in_ready), .we(we), .waddr(waddr), .wdata(wdata)
  );

  pfmt_word_ram #(.DEPTH(DEPTH), .DW(WORD_W)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata), .raddr(raddr), .rdata(rdata)
  );

  pfmt_rx_unpacker #(.AW(AW)) u_rx (
    .clk(clk), .rst_n(rst_n), .start(rx_start), .base(rx_base), .busy(rx_busy),
    .raddr(raddr), .rdata(rdata), .out_valid(rx_out_valid), .out_ready(rx_out_ready),
    .out_data(rx_out_data), .out_last(rx_out_last), .done(rx_done), .err(rx_err), .len(rx_len)
  );

  // R4: payload bytes are only requested while a write job runs
  p_ready_when_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_in_ready |-> tx_busy);
endmodule

// File: tb/pkt_frame_fmt_bench.sv
`timescale 1ns/1ps
module pkt_frame_fmt_bench;
  localparam int AW = 10;
  localparam int LW = 11;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic          tx_start = 1'b0;
  logic [AW-1:0] tx_base = '0;
  logic [LW-1:0] tx_len = '0;
  logic [15:0]   tx_status = '0;
  logic          tx_busy, tx_done, tx_in_ready;
  logic          tx_in_valid = 1'b0;
  logic [7:0]    tx_in_data = '0;
  logic          rx_start = 1'b0;
  logic [AW-1:0] rx_base = '0;
  logic          rx_busy, rx_out_valid, rx_out_last, rx_done, rx_err;
  logic          rx_out_ready = 1'b1;
  logic [7:0]    rx_out_data;
  logic [LW-1:0] rx_len;

  pkt_frame_fmt u_pkt_frame_fmt (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_base(tx_base), .tx_len(tx_len),
    .tx_status(tx_status), .tx_busy(tx_busy), .tx_done(tx_done), .tx_in_valid(tx_in_valid),
    .tx_in_data(tx_in_data), .tx_in_ready(tx_in_ready), .rx_start(rx_start), .rx_base(rx_base),
    .rx_busy(rx_busy), .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready),
    .rx_out_data(rx_out_data), .rx_out_last(rx_out_last), .rx_done(rx_done), .rx_err(rx_err),
    .rx_len(rx_len)
  );

  int checks = 0;
  int fails = 0;
  int done_seen = 0;
  int cyc = 0;
  logic [7:0]  exp_q[$];
  logic        exp_err = 1'b0;
  logic [LW-1:0] exp_len = '0;
  logic [7:0]  pb [0:2047];
  logic [15:0] img [0:1027];
  bit          rnd_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit          stall_prev = 1'b0;
  logic [7:0]  stall_data = '0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  // monitor: drives consumer ready, pops and compares bytes and results
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rx_out_ready = rnd_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
    if (rst_n) begin
      if (stall_prev)
        chk(rx_out_valid && rx_out_data == stall_data, "R8 hold under stall", rx_out_data, stall_data);
      stall_prev = rx_out_valid && !rx_out_ready;
      stall_data = rx_out_data;
      if (rx_out_valid && rx_out_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R6 R8 unexpected byte", rx_out_data, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rx_out_data == e, "R2 R3 R8 byte", rx_out_data, e);
          chk(rx_out_last == (exp_q.size() == 0), "R8 last flag", rx_out_last, exp_q.size() == 0);
        end
      end
      if (rx_done) begin
        done_seen++;
        chk(rx_err == exp_err, "R6 R7 error flag", rx_err, exp_err);
        chk(rx_len == exp_len, "R1 R5 length", rx_len, exp_len);
        chk(exp_q.size() == 0, "R9 bytes before done", exp_q.size(), 0);
      end
    end
  end

  task automatic do_tx(int base, int L, logic [15:0] st, int seed, bit gaps, bit poke);
    for (int i = 0; i < L; i++) pb[i] = 8'(seed * 7 + i * 13 + (i >> 3));
    img[0] = st;
    img[1] = 16'(L + 6);
    for (int w = 0; w < L / 2; w++) img[2 + w] = {pb[2*w+1], pb[2*w]};
    img[2 + L/2] = (L % 2 == 1) ? {8'h20, pb[L-1]} : 16'h0000;
    tx_start = 1'b1; tx_base = AW'(base); tx_len = LW'(L); tx_status = st;
    @(negedge clk);
    tx_start = 1'b0;
    for (int i = 0; i < L; i++) begin
      if (gaps && (i % 3 == 1)) begin tx_in_valid = 1'b0; @(negedge clk); end
      tx_in_valid = 1'b1;
      tx_in_data  = pb[i];
      if (poke && i == L / 2) begin
        tx_start = 1'b1; tx_base = AW'(base + 5); tx_len = 3; tx_status = 16'h8000;
      end
      #1;
      while (!tx_in_ready) begin @(negedge clk); tx_start = 1'b0; #1; end
      @(negedge clk);
      tx_start = 1'b0;
    end
    tx_in_valid = 1'b0;
    for (int t = 0; t < 20; t++) begin
      if (tx_done) break;
      @(negedge clk);
    end
    chk(tx_done, "R4 done pulse after control word", tx_done, 1);
    @(negedge clk);
    chk(!tx_done && !tx_busy && !tx_in_ready, "R4 idle after single done", {tx_done, tx_busy, tx_in_ready}, 0);
  endtask

  task automatic do_rx(int base, int L, logic [15:0] st, bit poke, bit rnd);
    int cnt, sum, d0;
    cnt = (L + 6) & 16'h07FF;
    sum = cnt + int'(st[12]);
    exp_q.delete();
    if ((st & 16'hAC00) != 0 || sum < 6) begin
      exp_err = 1'b1; exp_len = '0;
    end else begin
      exp_err = 1'b0; exp_len = LW'(sum - 6);
      for (int i = 0; i < sum - 6; i++) begin
        logic [15:0] w;
        w = img[2 + i/2];
        exp_q.push_back((i % 2 == 1) ? w[15:8] : w[7:0]);
      end
    end
    rnd_mode = rnd;
    d0 = done_seen;
    rx_start = 1'b1; rx_base = AW'(base);
    @(negedge clk);
    rx_start = 1'b0;
    for (int t = 0; t < 6000; t++) begin
      #1;
      if (done_seen != d0) break;
      if (poke && t == 10) begin rx_start = 1'b1; rx_base = AW'(base + 3); end
      else rx_start = 1'b0;
      @(negedge clk);
    end
    rx_start = 1'b0;
    chk(done_seen == d0 + 1, "R9 one done per job", done_seen - d0, 1);
    repeat (3) @(negedge clk);
    chk(done_seen == d0 + 1 && !rx_busy, "R11 R9 no second job", done_seen - d0, 1);
    chk(rx_err == exp_err && rx_len == exp_len, "R9 results held", {rx_err, rx_len}, {exp_err, exp_len});
    rnd_mode = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(!tx_busy && !tx_in_ready && !tx_done, "R4 reset state tx", {tx_busy, tx_in_ready, tx_done}, 0);
    chk(!rx_busy && !rx_out_valid && !rx_done && !rx_err && rx_len == 0, "R9 reset state rx",
        {rx_busy, rx_out_valid, rx_done, rx_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R5: even payload, plain status
    do_tx(0, 10, 16'h0000, 1, 1'b0, 1'b0);
    do_rx(0, 10, 16'h0000, 1'b0, 1'b0);
    // R3: odd payload, last byte in control word
    do_tx(40, 7, 16'h0000, 2, 1'b1, 1'b0);
    do_rx(40, 7, 16'h0000, 1'b0, 1'b0);
    // R3 R5: odd payload read with odd bit set exposes flag byte 0x20
    do_tx(80, 7, 16'h1000, 3, 1'b0, 1'b0);
    do_rx(80, 7, 16'h1000, 1'b0, 1'b0);
    // R3: even payload with odd bit set exposes zero control byte
    do_tx(120, 10, 16'h1000, 4, 1'b0, 1'b0);
    do_rx(120, 10, 16'h1000, 1'b0, 1'b0);
    // R6: error status bits
    do_tx(160, 4, 16'h8000, 5, 1'b0, 1'b0);
    do_rx(160, 4, 16'h8000, 1'b0, 1'b0);
    do_tx(170, 6, 16'h0400, 6, 1'b0, 1'b0);
    do_rx(170, 6, 16'h0400, 1'b0, 1'b0);
    // R5: empty and single-byte payloads
    do_tx(200, 0, 16'h0000, 7, 1'b0, 1'b0);
    do_rx(200, 0, 16'h0000, 1'b0, 1'b0);
    do_tx(210, 1, 16'h0000, 8, 1'b0, 1'b0);
    do_rx(210, 1, 16'h0000, 1'b0, 1'b0);
    // R10: packet wrapping past the top of the buffer
    do_tx(1020, 21, 16'h0000, 9, 1'b1, 1'b0);
    do_rx(1020, 21, 16'h0000, 1'b0, 1'b1);
    // R8 R11: stalls on output, extra start pulses on both sides
    do_tx(300, 60, 16'h0000, 10, 1'b1, 1'b1);
    do_rx(300, 60, 16'h0000, 1'b1, 1'b1);
    do_tx(400, 33, 16'h0000, 11, 1'b0, 1'b0);
    do_rx(400, 33, 16'h0000, 1'b0, 1'b1);
    // R7: maximum length makes the masked count wrap to zero
    do_tx(0, 2042, 16'h0000, 12, 1'b0, 1'b0);
    do_rx(0, 2042, 16'h0000, 1'b0, 1'b0);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule